// File: doc/BRIEF.md
# Burst Column Sequencer

This block produces the column addresses for one read or write burst of a synchronous graphics memory model. A command pulse supplies a start column and a direction. The mode fields are sampled at that pulse: burst length, ordering type, CAS latency and the single-write override. From the cycle after the command, the block presents one column per clock until the burst ends. A burst ends when its length runs out, when a stop request arrives, or when a new command replaces it.

For reads, a strobe marks the cycles in which read data would leave the array. This is the column stream delayed by the programmed CAS latency. Reads already in the pipeline still finish after their burst is cut short. When a read command cuts into a write burst, the block flags the write beat presented in that same cycle as masked. This leaves the data bus free before read data returns. The mode fields must stay unchanged while read strobes are still in flight.

Top module: `burst_col_seq`

## Requirements
- R1: After reset and until the first command, col_valid, rd_valid, burst_done and wr_mask are all low.
- R2: mode_bl codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. Code 7 gives a full-page burst, and codes 4 to 6 give 1 beat. Beats appear on consecutive cycles, starting in the cycle after the command, and beat 0 carries start_col.
- R3: With mode_il low, beat k of a burst of length L has column B + ((S mod L) + k) mod L. Here S is start_col and B is S rounded down to a multiple of L, so the burst wraps inside its aligned block.
- R4: With mode_il high, beat k has column B + ((S mod L) XOR (k mod L)), with S and B as in R3.
- R5: A full-page burst steps through 256 columns modulo 256 and continues until it is stopped or replaced.
- R6: burst_done is high only with the last beat of a burst that ran to its full length. It never rises for a full-page burst, a stopped burst or a replaced burst.
- R7: For a read issued in cycle T, rd_valid is high in cycle T+CL+k for each beat k that was presented. mode_cl codes 1, 2 and 3 set CL; code 0 acts as 1.
- R8: With mode_sw high, every write burst has one beat whatever mode_bl says. Reads keep their programmed length.
- R9: When stop is high in a cycle with a beat presented, that beat is the last one. stop while no burst runs has no effect.
- R10: A command during a burst ends the current burst. The new burst's beat 0 follows in the next cycle. Read strobes already in flight are still delivered.
- R11: wr_mask is high exactly in a cycle where a read command arrives while a write beat is presented.
- R12: col_is_wr shows, for each presented beat, whether its burst is a write (1) or a read (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Read or write command pulse |
| start_wr | input | 1 | Command direction, 1 = write |
| start_col | input | 8 | Start column of the burst |
| mode_bl | input | 3 | Burst length code |
| mode_il | input | 1 | Ordering, 1 = interleaved |
| mode_cl | input | 2 | CAS latency code |
| mode_sw | input | 1 | Single-write override |
| stop | input | 1 | Burst stop request |
| col_out | output | 8 | Column of the current beat |
| col_valid | output | 1 | A beat is presented |
| col_is_wr | output | 1 | Current beat belongs to a write |
| burst_done | output | 1 | Last beat of a burst that completed naturally |
| rd_valid | output | 1 | Read data strobe, delayed by the CAS latency |
| wr_mask | output | 1 | Current write beat must be masked |

## Verification
Some behaviours are checked by the assertions on every cycle. A command is followed by a beat carrying its start column and direction. A stop, or an idle cycle without a command, leaves nothing presented in the next cycle. burst_done and wr_mask only occur while a suitable beat is presented. With latency 1, the read strobe coincides with the read beat. Other behaviours can only be shown by the bench's scenarios: the exact column orderings for linear, interleaved and full-page bursts, the length codes and the single-write override, the strobe timing at latencies 2 and 3, and strobes that are still delivered after an interruption.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  parameter int COL_W = 8;
  typedef logic [COL_W-1:0] col_t;

  // Beat-index mask for a burst: length minus one, all ones for a full page.
  function automatic col_t len_mask(logic [2:0] bl, logic wr, logic sw);
    col_t m;
    if (wr && sw) return '0;
    case (bl)
      3'd1:    m = col_t'(1);
      3'd2:    m = col_t'(3);
      3'd3:    m = col_t'(7);
      3'd7:    m = '1;
      default: m = '0;
    endcase
    return m;
  endfunction

  // Column of a beat: the high bits stay fixed, the low bits step or flip.
  function automatic col_t beat_col(col_t base, col_t cnt, col_t mask, logic il);
    col_t low;
    low = il ? (base ^ cnt) : (base + cnt);
    return (base & ~mask) | (low & mask);
  endfunction
endpackage

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_wr,
  input  col_t       start_col,
  input  logic [2:0] mode_bl,
  input  logic       mode_il,
  input  logic       mode_sw,
  input  logic       stop,
  output logic       active,
  output col_t       cnt,
  output col_t       base,
  output col_t       mask,
  output logic       il,
  output logic       is_wr,
  output logic       last
);
  logic full;

  assign full = (mask == '1);
  assign last = active && !full && (cnt == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      base   <= '0;
      mask   <= '0;
      il     <= 1'b0;
      is_wr  <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      base   <= start_col;
      mask   <= len_mask(mode_bl, start_wr, mode_sw);
      il     <= mode_il;
      is_wr  <= start_wr;
    end else if (active) begin
      if (stop || last) active <= 1'b0;
      else              cnt    <= cnt + col_t'(1);
    end
  end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import bcs_pkg::*;
(
  input  col_t base,
  input  col_t cnt,
  input  col_t mask,
  input  logic il,
  output col_t col
);
  assign col = beat_col(base, cnt, mask, il);
endmodule

// File: rtl/bcs_rd_pipe.sv
module bcs_rd_pipe #(
  parameter int CL_MAX = 3,
  parameter int CL_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            beat_rd,
  input  logic [CL_W-1:0] cl,
  output logic            rd_valid
);
  localparam int DEPTH = (CL_MAX > 1) ? CL_MAX - 1 : 1;

  logic [DEPTH-1:0] sr;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sr[g] <= 1'b0;
          else        sr[g] <= beat_rd;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sr[g] <= 1'b0;
          else        sr[g] <= sr[g-1];
        end
      end
    end
  endgenerate

  always_comb begin
    rd_valid = beat_rd;
    for (int i = 0; i < DEPTH; i++) begin
      if (int'(cl) == i + 2) rd_valid = sr[i];
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int CL_MAX = 3,
  parameter int CL_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_wr,
  input  logic [7:0]      start_col,
  input  logic [2:0]      mode_bl,
  input  logic            mode_il,
  input  logic [CL_W-1:0] mode_cl,
  input  logic            mode_sw,
  input  logic            stop,
  output logic [7:0]      col_out,
  output logic            col_valid,
  output logic            col_is_wr,
  output logic            burst_done,
  output logic            rd_valid,
  output logic            wr_mask
);
  col_t cnt, base, mask;
  logic il, active, is_wr, last;
  logic beat_rd;

  bcs_beat_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wr(start_wr),
    .start_col(start_col), .mode_bl(mode_bl), .mode_il(mode_il),
    .mode_sw(mode_sw), .stop(stop), .active(active), .cnt(cnt),
    .base(base), .mask(mask), .il(il), .is_wr(is_wr), .last(last)
  );

  bcs_addr_gen u_addr (
    .base(base), .cnt(cnt), .mask(mask), .il(il), .col(col_out)
  );

  assign beat_rd = active && !is_wr;

  bcs_rd_pipe #(.CL_MAX(CL_MAX), .CL_W(CL_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .beat_rd(beat_rd), .cl(mode_cl),
    .rd_valid(rd_valid)
  );

  assign col_valid  = active;
  assign col_is_wr  = is_wr;
  assign burst_done = last;
  assign wr_mask    = start && !start_wr && active && is_wr;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int CL_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            start_wr,
  input logic [7:0]      start_col,
  input logic [CL_W-1:0] mode_cl,
  input logic            stop,
  input logic [7:0]      col_out,
  input logic            col_valid,
  input logic            col_is_wr,
  input logic            burst_done,
  input logic            rd_valid,
  input logic            wr_mask
);
  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid && col_out == $past(start_col)); // R2

  AST_BEAT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_is_wr == $past(start_wr)); // R12

  AST_DONE_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> col_valid); // R6

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && stop && !start |=> !col_valid); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid && !start |=> !col_valid); // R9

  AST_MASK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |-> col_valid && col_is_wr && start); // R11

  AST_MASK_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> col_valid && !col_is_wr); // R11

  AST_RD_LAT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cl <= CL_W'(1) && col_valid && !col_is_wr |-> rd_valid); // R7
endmodule

bind burst_col_seq burst_col_seq_chk #(.CL_W(CL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_wr(start_wr),
  .start_col(start_col), .mode_cl(mode_cl), .stop(stop),
  .col_out(col_out), .col_valid(col_valid), .col_is_wr(col_is_wr),
  .burst_done(burst_done), .rd_valid(rd_valid), .wr_mask(wr_mask)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, start_wr = 1'b0, mode_il = 1'b0, mode_sw = 1'b0, stop = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] mode_bl = '0;
  logic [1:0] mode_cl = 2'd1;
  logic [7:0] col_out;
  logic       col_valid, col_is_wr, burst_done, rd_valid, wr_mask;

  burst_col_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wr(start_wr),
    .start_col(start_col), .mode_bl(mode_bl), .mode_il(mode_il),
    .mode_cl(mode_cl), .mode_sw(mode_sw), .stop(stop), .col_out(col_out),
    .col_valid(col_valid), .col_is_wr(col_is_wr), .burst_done(burst_done),
    .rd_valid(rd_valid), .wr_mask(wr_mask)
  );

  always #2 clk = ~clk; // 250 MHz

  typedef struct { int col; bit wr; bit done; bit mask; } beat_t;
  beat_t bq[$];
  int    rq[$];
  int    cyc = 0;
  int    n_chk = 0, n_bad = 0;
  bit    finished = 1'b0;
  string tag = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // Monitor: compares presented beats and read strobes against the queues.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (col_valid) begin
        if (bq.size() == 0) chk(0, tag, 1, 0);
        else begin
          beat_t e;
          e = bq.pop_front();
          chk(col_out == e.col[7:0], tag, col_out, e.col);
          chk(col_is_wr == e.wr, "R12", col_is_wr, e.wr);
          chk(burst_done == e.done, "R6", burst_done, e.done);
          chk(wr_mask == e.mask, "R11", wr_mask, e.mask);
        end
      end else if (burst_done || wr_mask) begin
        chk(0, "R6 R11 idle", {burst_done, wr_mask}, 0);
      end
      if (rq.size() > 0 && rq[0] == cyc) begin
        chk(rd_valid == 1'b1, "R7", rd_valid, 1);
        void'(rq.pop_front());
      end else if (rd_valid) begin
        chk(0, "R7 unexpected strobe", 1, 0);
      end
    end
  end

  function automatic int exp_col(int s, int k, int len, bit il);
    int off, blk;
    off = s % len;
    blk = s - off;
    if (il) return blk + (off ^ (k % len));
    return blk + ((off + k) % len);
  endfunction

  function automatic int blen(int bl, bit wr, bit sw);
    if (wr && sw) return 1;
    case (bl)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 256;
      default: return 1;
    endcase
  endfunction

  // Driver: call at posedge+1. nxt: 0 natural end, 1 stop on beat n-1,
  // 2 another write follows on beat n-1, 3 a read follows on beat n-1.
  task automatic cmd(bit wr, int s, int bl, bit il, int cl, bit sw, int n, int nxt);
    int len, t0, ce;
    len = blen(bl, wr, sw);
    t0  = cyc;
    ce  = (cl == 0) ? 1 : cl;
    for (int k = 0; k < n; k++) begin
      beat_t b;
      b.col  = exp_col(s, k, len, il);
      b.wr   = wr;
      b.done = (nxt == 0) && (len != 256) && (k == len - 1);
      b.mask = wr && (nxt == 3) && (k == n - 1);
      bq.push_back(b);
      if (!wr) rq.push_back(t0 + ce + k);
    end
    start = 1'b1; start_wr = wr; start_col = s[7:0]; mode_bl = bl[2:0];
    mode_il = il; mode_cl = cl[1:0]; mode_sw = sw;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (n - 1) begin @(posedge clk); #1; end
    if (nxt == 1) begin
      stop = 1'b1;
      @(posedge clk); #1;
      stop = 1'b0;
    end else if (nxt == 0) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic drain;
    repeat (5) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) begin @(posedge clk); #1; end
    chk(!col_valid && !rd_valid && !burst_done && !wr_mask, "R1 in reset",
        {col_valid, rd_valid, burst_done, wr_mask}, 0);
    rst_n = 1'b1;
    repeat (2) begin @(posedge clk); #1; end
    chk(!col_valid && !rd_valid && !burst_done && !wr_mask, "R1 after reset",
        {col_valid, rd_valid, burst_done, wr_mask}, 0);

    tag = "R3 linear len4"; cmd(0, 8'h0D, 2, 0, 2, 0, 4, 0); drain();
    tag = "R4 interleave len8"; cmd(0, 8'h35, 3, 1, 3, 0, 8, 0); drain();
    tag = "R3 write len2 wrap"; cmd(1, 8'hFF, 1, 0, 1, 0, 2, 0); drain();
    tag = "R8 single write"; cmd(1, 8'h44, 3, 0, 1, 1, 1, 0); drain();
    tag = "R8 read keeps length"; cmd(0, 8'h44, 3, 0, 1, 1, 8, 0); drain();
    tag = "R7 latency code 0"; cmd(0, 8'h21, 0, 0, 0, 0, 1, 0); drain();
    tag = "R2 reserved code"; cmd(0, 8'h22, 5, 0, 2, 0, 1, 0); drain();
    tag = "R2 interleave len2"; cmd(0, 8'h61, 1, 1, 3, 0, 2, 0); drain();
    tag = "R5 full page linear"; cmd(0, 8'hFC, 7, 0, 1, 0, 6, 1); drain();
    tag = "R5 full page interleave"; cmd(1, 8'h03, 7, 1, 1, 0, 5, 1); drain();
    tag = "R5 full page long"; cmd(0, 8'h80, 7, 0, 2, 0, 260, 1); drain();
    tag = "R9 stop read"; cmd(0, 8'h10, 3, 0, 3, 0, 3, 1); drain();

    // R9: stop with no burst running leaves the outputs idle.
    tag = "R9 idle stop";
    stop = 1'b1; @(posedge clk); #1; stop = 1'b0;
    chk(!col_valid, "R9 idle stop", col_valid, 0);
    @(posedge clk); #1;
    chk(!col_valid, "R9 idle stop", col_valid, 0);

    // R10/R11: a read cuts into a write; the overlapping write beat is masked.
    tag = "R10 read over write";
    cmd(1, 8'h10, 3, 0, 2, 0, 3, 3);
    cmd(0, 8'h20, 2, 0, 2, 0, 4, 0); drain();

    // R10: a write cuts into a latency-3 read; the read strobes still arrive.
    tag = "R10 write over read";
    cmd(0, 8'h40, 3, 0, 3, 0, 2, 2);
    cmd(1, 8'h52, 2, 1, 3, 0, 4, 0); drain();

    // R10: a read replaces a read.
    tag = "R10 read over read";
    cmd(0, 8'h77, 3, 1, 2, 0, 5, 3);
    cmd(0, 8'h9A, 1, 0, 2, 0, 2, 0); drain();

    chk(bq.size() == 0, "R2 beats outstanding", bq.size(), 0);
    chk(rq.size() == 0, "R7 strobes outstanding", rq.size(), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule